// File: doc/BRIEF.md
# UART FIFO Trigger and Level Register Bank

This block is the small register bank that lives next to a UART's receive and transmit FIFOs. It holds a feature control byte, a pair of programmable trigger thresholds, a scratchpad byte and an enhanced-mode byte. It turns the FIFO occupancy counts that it receives into an effective threshold and a trigger-reached flag for each direction. The FIFOs themselves, the serial shifters and the baud logic sit elsewhere. This block only stores configuration and answers register-bus reads.

Access goes over a byte-wide bus with an address, a read strobe, a write strobe and write data. Read data is combinational and is valid while the read strobe is high. The feature control byte, the programmable trigger register and a read-only level-count register are reachable only while the UART's line control value, given as an input, equals the configuration key 0xBF. At any other line control value, only the scratchpad address is served. A direction bit in the feature control byte steers both trigger writes and level-count reads between RX and TX. A swap bit turns the scratchpad address into a window that reads the FIFO count and, on a write, loads the enhanced-mode byte.

Top module: `uart_fifo_trig_regs`

## Requirements
- R1: After reset every register is 0. Table A is selected, both fixed-code inputs at 0 give RX and TX thresholds of 8, inversion and half-duplex are 0, the enhanced-mode byte is 0 and the scratchpad reads 0.
- R2: With the line control value at 0xBF, a write to address 0 stores bits 7:2 of the feature control byte, and bits 1:0 always read 0. Bit 2 drives irda_rx_invert, bit 3 drives half_duplex_en and bits 5:4 drive table_sel. A write to address 0 at any other line control value changes nothing.
- R3: With the line control value at 0xBF, a write to address 1 loads the RX programmed threshold when feature bit 7 is 0 and the TX programmed threshold when it is 1. The other threshold is left unchanged. A read of address 1 returns the threshold of the direction that bit 7 selects.
- R4: When table_sel is 3 (table D), the effective thresholds are the programmed values, whatever the code inputs are.
- R5: Tables A, B and C (table_sel 0, 1 and 2) take their thresholds from constants indexed by the 2-bit code inputs 0..3. A gives RX 8,16,56,60 and TX 8,16,32,56. B gives RX 1,4,8,14 and TX 2,4,8,12. C gives RX 16,24,40,48 and TX 8,16,24,40.
- R6: rx_trig_hit is 1 exactly when rx_count is at or above the RX threshold. tx_trig_hit is 1 exactly when tx_count is at or below the TX threshold.
- R7: With the line control value at 0xBF, address 2 reads rx_count when feature bit 7 is 0 and tx_count when it is 1, zero-extended. Writes to address 2 change nothing. At any other line control value, address 2 reads 0.
- R8: With the line control value not 0xBF and feature bit 6 at 0, address 7 is a plain read/write scratchpad byte.
- R9: With feature bit 6 at 1, a read of address 7 returns the count selected by bit 7. A write to address 7 loads enh_mode and leaves the scratchpad byte unchanged.
- R10: reg_rdata is 0 whenever reg_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, 0 when reg_rd is low |
| lcr_val | input | 8 | Current line control value; 0xBF opens the configuration page |
| rx_level_code | input | 2 | RX threshold index for tables A to C |
| tx_level_code | input | 2 | TX threshold index for tables A to C |
| rx_count | input | CNT_W | RX FIFO occupancy |
| tx_count | input | CNT_W | TX FIFO occupancy |
| table_sel | output | 2 | Selected trigger table (0=A, 1=B, 2=C, 3=D) |
| rx_threshold | output | 8 | Effective RX threshold |
| tx_threshold | output | 8 | Effective TX threshold |
| irda_rx_invert | output | 1 | IrDA receive inversion (idle high when 1) |
| half_duplex_en | output | 1 | Half-duplex override |
| enh_mode | output | 8 | Enhanced-mode byte |
| rx_trig_hit | output | 1 | RX count at or above threshold |
| tx_trig_hit | output | 1 | TX count at or below threshold |

## Verification
The bench drives the threshold compare exactly at equality and one step on each side in both directions. A design with the wrong comparison sense or a strict comparison gives the wrong flag at those points. It alternates the direction bit between trigger writes and readbacks, which catches a design that loads both thresholds or returns the wrong one. It writes through the scratchpad window with the swap bit set and then clears the bit to read the old scratchpad back, which exposes a write that leaks into the scratchpad. It also sends writes to the configuration addresses and reads the level count with the line control value away from 0xBF, which exposes a gate on the configuration page that is missing or sits in the wrong place.

// File: rtl/utr_pkg.sv
package utr_pkg;

    localparam logic [7:0] CFG_KEY   = 8'hBF;
    localparam int         A_FCTL    = 0;
    localparam int         A_TRIG    = 1;
    localparam int         A_LEVEL   = 2;
    localparam int         A_SPAD    = 7;

    // Feature control bit positions
    localparam int FB_INV  = 2;
    localparam int FB_HDX  = 3;
    localparam int FB_TLO  = 4;
    localparam int FB_SWAP = 6;
    localparam int FB_DIR  = 7;

    typedef struct packed {
        logic [7:0] fctl;
        logic [7:0] rx_prog;
        logic [7:0] tx_prog;
        logic [7:0] spad;
        logic [7:0] emode;
    } utr_regs_t;

    // Fixed thresholds of tables A..C (table D handled by caller)
    function automatic logic [7:0] fixed_thr(input logic is_tx,
                                             input logic [1:0] tbl,
                                             input logic [1:0] code);
        logic [7:0] r;
        r = 8'd0;
        case ({is_tx, tbl})
            3'b0_00: case (code) 2'd0: r = 8'd8;  2'd1: r = 8'd16; 2'd2: r = 8'd56; default: r = 8'd60; endcase
            3'b0_01: case (code) 2'd0: r = 8'd1;  2'd1: r = 8'd4;  2'd2: r = 8'd8;  default: r = 8'd14; endcase
            3'b0_10: case (code) 2'd0: r = 8'd16; 2'd1: r = 8'd24; 2'd2: r = 8'd40; default: r = 8'd48; endcase
            3'b1_00: case (code) 2'd0: r = 8'd8;  2'd1: r = 8'd16; 2'd2: r = 8'd32; default: r = 8'd56; endcase
            3'b1_01: case (code) 2'd0: r = 8'd2;  2'd1: r = 8'd4;  2'd2: r = 8'd8;  default: r = 8'd12; endcase
            3'b1_10: case (code) 2'd0: r = 8'd8;  2'd1: r = 8'd16; 2'd2: r = 8'd24; default: r = 8'd40; endcase
            default: r = 8'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/utr_regfile.sv
module utr_regfile
    import utr_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [7:0]        wdata,
    input  logic              cfg_open,
    output utr_regs_t         regs
);

    localparam logic [ADDR_W-1:0] AD_FCTL = ADDR_W'(A_FCTL);
    localparam logic [ADDR_W-1:0] AD_TRIG = ADDR_W'(A_TRIG);
    localparam logic [ADDR_W-1:0] AD_SPAD = ADDR_W'(A_SPAD);

    utr_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr) begin
            if (cfg_open) begin
                if (addr == AD_FCTL) begin
                    regs_d.fctl = {wdata[7:2], 2'b00};
                end else if (addr == AD_TRIG) begin
                    if (regs_q.fctl[FB_DIR]) regs_d.tx_prog = wdata;
                    else                     regs_d.rx_prog = wdata;
                end
            end else if (addr == AD_SPAD) begin
                if (regs_q.fctl[FB_SWAP]) regs_d.emode = wdata;
                else                      regs_d.spad  = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.fctl[1:0] == 2'b00);

    assert_closed_fctl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !cfg_open && addr == AD_FCTL) |=> $stable(regs_q.fctl));

    assert_trig_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && cfg_open && addr == AD_TRIG && !regs_q.fctl[FB_DIR]) |=> $stable(regs_q.tx_prog));

    assert_swap_keeps_spad_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !cfg_open && addr == AD_SPAD && regs_q.fctl[FB_SWAP]) |=> $stable(regs_q.spad));

endmodule

// File: rtl/utr_thresh.sv
module utr_thresh
    import utr_pkg::*;
#(
    parameter int CNT_W = 7,
    parameter bit IS_TX = 1'b0
) (
    input  logic [1:0]       tbl,
    input  logic [1:0]       code,
    input  logic [7:0]       prog,
    input  logic [CNT_W-1:0] cnt,
    output logic [7:0]       thr,
    output logic             hit
);

    logic [7:0] cnt_ext;

    always_comb begin
        cnt_ext = 8'(cnt);
        thr     = (tbl == 2'd3) ? prog : fixed_thr(IS_TX, tbl, code);
    end

    generate
        if (IS_TX) begin : g_tx
            assign hit = (cnt_ext <= thr);
        end else begin : g_rx
            assign hit = (cnt_ext >= thr);
        end
    endgenerate

endmodule

// File: rtl/utr_rdmux.sv
module utr_rdmux
    import utr_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              cfg_open,
    input  utr_regs_t         regs,
    input  logic [CNT_W-1:0]  rx_cnt,
    input  logic [CNT_W-1:0]  tx_cnt,
    output logic [7:0]        rdata
);

    localparam logic [ADDR_W-1:0] AD_FCTL  = ADDR_W'(A_FCTL);
    localparam logic [ADDR_W-1:0] AD_TRIG  = ADDR_W'(A_TRIG);
    localparam logic [ADDR_W-1:0] AD_LEVEL = ADDR_W'(A_LEVEL);
    localparam logic [ADDR_W-1:0] AD_SPAD  = ADDR_W'(A_SPAD);

    logic [7:0] level_sel;

    always_comb begin
        level_sel = regs.fctl[FB_DIR] ? 8'(tx_cnt) : 8'(rx_cnt);
        rdata     = 8'h00;
        if (rd) begin
            if (cfg_open) begin
                if (addr == AD_FCTL)       rdata = regs.fctl;
                else if (addr == AD_TRIG)  rdata = regs.fctl[FB_DIR] ? regs.tx_prog : regs.rx_prog;
                else if (addr == AD_LEVEL) rdata = level_sel;
            end else if (addr == AD_SPAD) begin
                rdata = regs.fctl[FB_SWAP] ? level_sel : regs.spad;
            end
        end
    end

endmodule

// File: rtl/uart_fifo_trig_regs.sv
module uart_fifo_trig_regs
    import utr_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [7:0]        lcr_val,
    input  logic [1:0]        rx_level_code,
    input  logic [1:0]        tx_level_code,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  tx_count,
    output logic [1:0]        table_sel,
    output logic [7:0]        rx_threshold,
    output logic [7:0]        tx_threshold,
    output logic              irda_rx_invert,
    output logic              half_duplex_en,
    output logic [7:0]        enh_mode,
    output logic              rx_trig_hit,
    output logic              tx_trig_hit
);

    utr_regs_t regs;
    logic      cfg_open;

    assign cfg_open = (lcr_val == CFG_KEY);

    utr_regfile #(.ADDR_W(ADDR_W)) u_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (reg_addr),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .cfg_open (cfg_open),
        .regs     (regs)
    );

    utr_thresh #(.CNT_W(CNT_W), .IS_TX(1'b0)) u_rx_thr (
        .tbl  (regs.fctl[FB_TLO +: 2]),
        .code (rx_level_code),
        .prog (regs.rx_prog),
        .cnt  (rx_count),
        .thr  (rx_threshold),
        .hit  (rx_trig_hit)
    );

    utr_thresh #(.CNT_W(CNT_W), .IS_TX(1'b1)) u_tx_thr (
        .tbl  (regs.fctl[FB_TLO +: 2]),
        .code (tx_level_code),
        .prog (regs.tx_prog),
        .cnt  (tx_count),
        .thr  (tx_threshold),
        .hit  (tx_trig_hit)
    );

    utr_rdmux #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rdmux (
        .addr     (reg_addr),
        .rd       (reg_rd),
        .cfg_open (cfg_open),
        .regs     (regs),
        .rx_cnt   (rx_count),
        .tx_cnt   (tx_count),
        .rdata    (reg_rdata)
    );

    assign table_sel      = regs.fctl[FB_TLO +: 2];
    assign irda_rx_invert = regs.fctl[FB_INV];
    assign half_duplex_en = regs.fctl[FB_HDX];
    assign enh_mode       = regs.emode;

    assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> reg_rdata == 8'h00);

    assert_table_d_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (table_sel == 2'd3) |-> (rx_threshold == regs.rx_prog && tx_threshold == regs.tx_prog));

endmodule

// File: tb/uart_fifo_trig_regs_bench.sv
module uart_fifo_trig_regs_bench;

    localparam int ADDR_W = 3;
    localparam int CNT_W  = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_rd = 1'b0;
    logic              reg_wr = 1'b0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic [7:0]        lcr_val = 8'h00;
    logic [1:0]        rx_level_code = '0;
    logic [1:0]        tx_level_code = '0;
    logic [CNT_W-1:0]  rx_count = '0;
    logic [CNT_W-1:0]  tx_count = '0;
    logic [1:0]        table_sel;
    logic [7:0]        rx_threshold, tx_threshold, enh_mode;
    logic              irda_rx_invert, half_duplex_en, rx_trig_hit, tx_trig_hit;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #4 clk = ~clk;

    uart_fifo_trig_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_uart_fifo_trig_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lcr_val(lcr_val),
        .rx_level_code(rx_level_code), .tx_level_code(tx_level_code),
        .rx_count(rx_count), .tx_count(tx_count), .table_sel(table_sel),
        .rx_threshold(rx_threshold), .tx_threshold(tx_threshold),
        .irda_rx_invert(irda_rx_invert), .half_duplex_en(half_duplex_en),
        .enh_mode(enh_mode), .rx_trig_hit(rx_trig_hit), .tx_trig_hit(tx_trig_hit)
    );

    // {tbl, rx_code, tx_code, rx_cnt, tx_cnt, exp_rx_thr, exp_tx_thr, exp_rx_hit, exp_tx_hit}
    localparam int NV = 9;
    localparam logic [37:0] VEC [NV] = '{
        {2'd0, 2'd0, 2'd0, 7'd8,  7'd8,  8'd8,  8'd8,  1'b1, 1'b1},
        {2'd0, 2'd3, 2'd2, 7'd59, 7'd33, 8'd60, 8'd32, 1'b0, 1'b0},
        {2'd0, 2'd2, 2'd3, 7'd56, 7'd56, 8'd56, 8'd56, 1'b1, 1'b1},
        {2'd1, 2'd0, 2'd1, 7'd0,  7'd4,  8'd1,  8'd4,  1'b0, 1'b1},
        {2'd1, 2'd3, 2'd3, 7'd14, 7'd13, 8'd14, 8'd12, 1'b1, 1'b0},
        {2'd2, 2'd1, 2'd0, 7'd23, 7'd9,  8'd24, 8'd8,  1'b0, 1'b0},
        {2'd2, 2'd3, 2'd3, 7'd64, 7'd40, 8'd48, 8'd40, 1'b1, 1'b1},
        {2'd3, 2'd0, 2'd0, 7'd19, 7'd10, 8'd20, 8'd10, 1'b0, 1'b1},
        {2'd3, 2'd3, 2'd1, 7'd20, 7'd11, 8'd20, 8'd10, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] lcr, input int a, input logic [7:0] d);
        @(negedge clk);
        lcr_val = lcr; reg_addr = ADDR_W'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] lcr, input int a, output logic [7:0] d);
        @(negedge clk);
        lcr_val = lcr; reg_addr = ADDR_W'(a); reg_rd = 1'b1;
        #2 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 table_sel", {6'd0, table_sel}, 8'd0);
        check("R1 rx_thr", rx_threshold, 8'd8);
        check("R1 tx_thr", tx_threshold, 8'd8);
        check("R1 flags", {6'd0, irda_rx_invert, half_duplex_en}, 8'd0);
        check("R1 enh", enh_mode, 8'd0);
        check("R1 hits", {6'd0, rx_trig_hit, tx_trig_hit}, 8'b01);
        rd_reg(8'h00, 7, v); check("R1 spad", v, 8'h00);

        // R2 feature control
        wr_reg(8'hBF, 0, 8'hFF);
        rd_reg(8'hBF, 0, v); check("R2 rsvd bits", v, 8'hFC);
        check("R2 sel/inv/hdx", {3'd0, table_sel, irda_rx_invert, half_duplex_en, 1'b0}, 8'b000_11_1_1_0);
        wr_reg(8'hBF, 0, 8'h04);
        check("R2 inv only", {6'd0, irda_rx_invert, half_duplex_en}, 8'b10);
        wr_reg(8'h03, 0, 8'hF0);
        rd_reg(8'hBF, 0, v); check("R2 closed write ignored", v, 8'h04);

        // R3 trigger direction, R4 table D
        wr_reg(8'hBF, 0, 8'h30);
        wr_reg(8'hBF, 1, 8'd20);
        wr_reg(8'hBF, 0, 8'hB0);
        wr_reg(8'hBF, 1, 8'd10);
        rd_reg(8'hBF, 1, v); check("R3 tx readback", v, 8'd10);
        wr_reg(8'hBF, 0, 8'h30);
        rd_reg(8'hBF, 1, v); check("R3 rx readback", v, 8'd20);
        check("R4 rx thr D", rx_threshold, 8'd20);
        check("R4 tx thr D", tx_threshold, 8'd10);

        // R5/R6/R4 vector walk
        for (int i = 0; i < NV; i++) begin
            wr_reg(8'hBF, 0, {2'b00, VEC[i][37:36], 4'b0000});
            @(negedge clk);
            rx_level_code = VEC[i][35:34];
            tx_level_code = VEC[i][33:32];
            rx_count      = VEC[i][31:25];
            tx_count      = VEC[i][24:18];
            #2;
            check($sformatf("R5 rx thr vec%0d", i), rx_threshold, VEC[i][17:10]);
            check($sformatf("R5 tx thr vec%0d", i), tx_threshold, VEC[i][9:2]);
            check($sformatf("R6 hits vec%0d", i), {6'd0, rx_trig_hit, tx_trig_hit}, {6'd0, VEC[i][1:0]});
        end

        // R7 level count
        @(negedge clk); rx_count = 7'd37; tx_count = 7'd5;
        wr_reg(8'hBF, 0, 8'h00);
        rd_reg(8'hBF, 2, v); check("R7 rx level", v, 8'd37);
        wr_reg(8'hBF, 0, 8'h80);
        rd_reg(8'hBF, 2, v); check("R7 tx level", v, 8'd5);
        wr_reg(8'hBF, 2, 8'hAA);
        rd_reg(8'hBF, 0, v); check("R7 write ignored fctl", v, 8'h80);
        rd_reg(8'hBF, 1, v); check("R7 write ignored trig", v, 8'd10);
        rd_reg(8'h00, 2, v); check("R7 closed read", v, 8'h00);

        // R8 scratchpad
        wr_reg(8'hBF, 0, 8'h00);
        wr_reg(8'h00, 7, 8'h5A);
        rd_reg(8'h00, 7, v); check("R8 spad", v, 8'h5A);

        // R9 swap
        wr_reg(8'hBF, 0, 8'h40);
        rd_reg(8'h00, 7, v); check("R9 swap rx count", v, 8'd37);
        wr_reg(8'hBF, 0, 8'hC0);
        rd_reg(8'h00, 7, v); check("R9 swap tx count", v, 8'd5);
        wr_reg(8'h00, 7, 8'h3C);
        check("R9 enh loaded", enh_mode, 8'h3C);
        wr_reg(8'hBF, 0, 8'h00);
        rd_reg(8'h00, 7, v); check("R9 spad kept", v, 8'h5A);

        // R10 idle bus
        @(negedge clk); lcr_val = 8'h00; reg_addr = 3'd7; reg_rd = 1'b0;
        #2 check("R10 idle rdata", reg_rdata, 8'h00);

        done = 1'b1;
        finish_run();
    end

endmodule